// File: doc/BRIEF.md
# Multi-Model Fault Saboteur

This block sits on one signal or one register of a design under test and hands back a value that may be corrupted. The value replaces the original wherever the original was used. A single fault-enable line switches the corruption on. A two-bit model select chooses the fault model: forcing to zero, forcing to one, a transient inversion that lasts only while the enable is high, or an upset of a storage element. The stuck and transient models act combinationally on the signal.

The upset model is different. It feeds the value through an internal flip-flop with an inverting multiplexer in front of it. Whether a flip happens in a given cycle is decided by a pseudo-random bit taken from a 127-entry table that is computed at elaboration. The table index moves forward once per clock while the enable is high.

One parameter, `WIDTH`, picks the variant. A width of one gives the scalar variant. A larger width gives the vector variant, in which the table index modulo the width selects which bit is inverted.

Top module: `fault_saboteur`

## Requirements
- R1: With model select 2'b00 and the fault enable high, every output bit is 0 in the same cycle.
- R2: With model select 2'b01 and the fault enable high, every output bit is 1 in the same cycle.
- R3: With model select 2'b10 and the fault enable high, the output is the bitwise inverse of the input in the same cycle. The output equals the input again in the cycle in which the enable is low.
- R4: With model select 2'b00, 2'b01 or 2'b10 and the fault enable low, the output equals the input combinationally.
- R5: With model select 2'b11, the output is the internal register. On each clock edge where no flip is taken, the register loads the input unchanged, so the output shows it one cycle later.
- R6: With model select 2'b11, if the fault enable and the current random bit are both 1 at a clock edge, the register loads the input with exactly bit position (index mod WIDTH) inverted. Both the index and the random bit are the values held before that edge.
- R7: Random table entry k is bit 0 of state s_k. The states start at s_0 = 7'b0000001 and step as s_{k+1} = {s_k[5:0], s_k[6] ^ s_k[5]}. The bit used in a cycle is the entry at the current index.
- R8: The table index advances by one on every clock edge at which the fault enable is high, whatever the model. It holds otherwise, and it wraps from TABLE_LEN-1 (126 by default) to 0.
- R9: While reset is low, the register and the index are 0. With model select 2'b11 the output is therefore 0.
- R10: The scalar variant (WIDTH = 1) behaves the same way, and its upset always inverts bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_i | input | WIDTH | Original signal value |
| inject_i | input | 1 | Fault enable, active high |
| mode_i | input | 2 | Fault model select (00 zero, 01 one, 10 invert, 11 upset) |
| data_o | output | WIDTH | Possibly corrupted value |

## Verification
Two things fall on the same clock edge: the table index advancing, and the upset decision that reads the index. The bench holds the enable high for more than 127 consecutive upset cycles, so the index wraps while flips are being decided. It checks each captured value against a model that uses the index from before the edge. The index also advances while a stuck or transient model is selected. The sweeps therefore switch models with the enable high, and the later upset pattern shows whether those cycles were counted.

// File: rtl/fsab_pkg.sv
package fsab_pkg;

   typedef enum logic [1:0] {
      FM_STUCK0 = 2'b00,
      FM_STUCK1 = 2'b01,
      FM_INVERT = 2'b10,
      FM_UPSET  = 2'b11
   } fault_mode_e;

   localparam int unsigned RND_PERIOD = 127;
   localparam int unsigned RND_SW     = 7;

   // Entry k = bit 0 of the k-th state of a 7-bit maximal-length shift register.
   function automatic logic [RND_PERIOD-1:0] build_rnd_table();
      logic [RND_PERIOD-1:0] t;
      logic [RND_SW-1:0]     s;
      t = '0;
      s = 7'h01;
      for (int k = 0; k < RND_PERIOD; k++) begin
         t[k] = s[0];
         s    = {s[5:0], s[6] ^ s[5]};
      end
      return t;
   endfunction

endpackage

// File: rtl/fsab_rand.sv
module fsab_rand
   import fsab_pkg::*;
#(
   parameter int unsigned TABLE_LEN = RND_PERIOD,
   parameter int unsigned IW        = $clog2(TABLE_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step_i,
   output logic [IW-1:0] idx_o,
   output logic          bit_o
);

   localparam logic [RND_PERIOD-1:0] TBL  = build_rnd_table();
   localparam logic [IW-1:0]         LAST = IW'(TABLE_LEN - 1);

   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx_q <= '0;
      else if (step_i)
         idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
   end

   assign idx_o = idx_q;
   assign bit_o = TBL[idx_q];

   // R8: the index never leaves the table
   assert_idx_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST);
   // R8: wrap from last entry to zero
   assert_idx_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && idx_q == LAST) |=> idx_q == '0);
   // R8: no movement without the enable
   assert_idx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(idx_q));

endmodule

// File: rtl/fsab_upset.sv
module fsab_upset #(
   parameter int unsigned W  = 4,
   parameter int unsigned IW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d_i,
   input  logic          fire_i,
   input  logic [IW-1:0] idx_i,
   output logic [W-1:0]  q_o
);

   logic [W-1:0] mask;
   logic [W-1:0] d_mux;

   generate
      if (W == 1) begin : g_scalar
         assign mask = 1'b1;
      end else begin : g_vector
         logic [IW-1:0] pos;
         assign pos  = idx_i % IW'(W);
         assign mask = W'(1) << pos;
      end
   endgenerate

   // Inverting multiplexer ahead of the storage element
   assign d_mux = fire_i ? (d_i ^ mask) : d_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d_mux;
   end

   // R5: plain capture when no flip is taken
   assert_plain_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fire_i |=> q_o == $past(d_i));
   // R6: a taken flip changes exactly one bit
   assert_single_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |=> $countones(q_o ^ $past(d_i)) == 1);

endmodule

// File: rtl/fsab_comb.sv
module fsab_comb
   import fsab_pkg::*;
#(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] data_i,
   input  logic         inject_i,
   input  fault_mode_e  mode_i,
   input  logic [W-1:0] q_i,
   output logic [W-1:0] data_o
);

   always_comb begin
      data_o = data_i;
      unique case (mode_i)
         FM_STUCK0: if (inject_i) data_o = '0;
         FM_STUCK1: if (inject_i) data_o = '1;
         FM_INVERT: if (inject_i) data_o = ~data_i;
         FM_UPSET:  data_o = q_i;
         default:   data_o = data_i;
      endcase
   end

endmodule

// File: rtl/fault_saboteur.sv
module fault_saboteur
   import fsab_pkg::*;
#(
   parameter int unsigned WIDTH     = 4,
   parameter int unsigned TABLE_LEN = RND_PERIOD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] data_i,
   input  logic             inject_i,
   input  logic [1:0]       mode_i,
   output logic [WIDTH-1:0] data_o
);

   localparam int unsigned IW = $clog2(TABLE_LEN);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("fault_saboteur: WIDTH must be at least 1");
      end
      if (TABLE_LEN < 2 || TABLE_LEN > RND_PERIOD) begin : g_bad_len
         $error("fault_saboteur: TABLE_LEN must lie in 2..127");
      end
   endgenerate

   fault_mode_e   mode;
   logic [IW-1:0] idx;
   logic          rnd;
   logic          fire;
   logic [WIDTH-1:0] q;

   assign mode = fault_mode_e'(mode_i);
   assign fire = inject_i && (mode == FM_UPSET) && rnd;

   fsab_rand #(.TABLE_LEN(TABLE_LEN), .IW(IW)) u_rand (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (inject_i),
      .idx_o  (idx),
      .bit_o  (rnd)
   );

   fsab_upset #(.W(WIDTH), .IW(IW)) u_upset (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (data_i),
      .fire_i (fire),
      .idx_i  (idx),
      .q_o    (q)
   );

   fsab_comb #(.W(WIDTH)) u_comb (
      .data_i   (data_i),
      .inject_i (inject_i),
      .mode_i   (mode),
      .q_i      (q),
      .data_o   (data_o)
   );

   // R1
   assert_stuck_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_i && mode_i == 2'b00) |-> data_o == '0);
   // R2
   assert_stuck_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_i && mode_i == 2'b01) |-> data_o == '1);
   // R3
   assert_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_i && mode_i == 2'b10) |-> data_o == ~data_i);
   // R4
   assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!inject_i && mode_i != 2'b11) |-> data_o == data_i);

endmodule

// File: tb/fault_saboteur_tb.sv
`timescale 1ns/1ps
module fault_saboteur_tb;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] d = '0;
   logic         inj = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic [W-1:0] out_v;
   logic         out_s;

   int total = 0;
   int bad   = 0;

   logic [126:0] tbl;
   int           idx_m = 0;
   logic [W-1:0] q_m = '0;
   logic         qs_m = 1'b0;

   always #2.5 clk = ~clk;

   fault_saboteur #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .data_i(d), .inject_i(inj),
      .mode_i(mode), .data_o(out_v));

   fault_saboteur #(.WIDTH(1)) u_dut_bit (
      .clk(clk), .rst_n(rst_n), .data_i(d[0]), .inject_i(inj),
      .mode_i(mode), .data_o(out_s));

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h mode=%0d inj=%0d d=%h idx=%0d",
                  req, act, exp, mode, inj, d, idx_m);
      end
   endtask

   function automatic string req_of(input logic [1:0] m, input logic i);
      if (m == 2'b11) return "R5/R6/R7";
      if (!i)         return "R4";
      if (m == 2'b00) return "R1";
      if (m == 2'b01) return "R2";
      return "R3";
   endfunction

   // one cycle: drive after falling edge, check, then model the rising edge
   task automatic step(input logic [W-1:0] dv, input logic iv, input logic [1:0] mv);
      logic [W-1:0] ev;
      logic         es;
      @(negedge clk);
      d = dv; inj = iv; mode = mv;
      #1;
      case (mv)
         2'b00: begin ev = iv ? '0 : dv;  es = iv ? 1'b0 : dv[0]; end
         2'b01: begin ev = iv ? '1 : dv;  es = iv ? 1'b1 : dv[0]; end
         2'b10: begin ev = iv ? ~dv : dv; es = iv ? ~dv[0] : dv[0]; end
         default: begin ev = q_m; es = qs_m; end
      endcase
      check(req_of(mv, iv), out_v, ev);
      check("R10", {{(W-1){1'b0}}, out_s}, {{(W-1){1'b0}}, es});
      @(posedge clk);
      if (mv == 2'b11 && iv && tbl[idx_m]) begin
         q_m  = dv ^ (W'(1) << (idx_m % W));
         qs_m = ~dv[0];
      end else begin
         q_m  = dv;
         qs_m = dv[0];
      end
      if (iv) idx_m = (idx_m == 126) ? 0 : idx_m + 1;
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [6:0] s;
      s = 7'h01;
      for (int k = 0; k < 127; k++) begin
         tbl[k] = s[0];
         s = {s[5:0], s[6] ^ s[5]};
      end

      // R9: reset state, upset model shows the cleared register
      mode = 2'b11; d = 4'hA; inj = 1'b1;
      #12;
      check("R9", out_v, '0);
      check("R9", {3'b000, out_s}, '0);
      @(negedge clk);
      inj = 1'b0;
      rst_n = 1'b1;

      // exhaustive sweep over models, enable and input values
      for (int m = 0; m < 4; m++)
         for (int i = 0; i < 2; i++)
            for (int v = 0; v < 16; v++)
               step(W'(v), i[0], m[1:0]);

      // R3: enable drops, output follows input in the same cycle
      step(4'h5, 1'b1, 2'b10);
      step(4'h5, 1'b0, 2'b10);

      // R8: long upset run crosses the wrap of the index
      for (int c = 0; c < 300; c++)
         step(W'(c * 7 + 3), 1'b1, 2'b11);

      // R8: enable low holds the index, then model switches with enable high
      for (int c = 0; c < 20; c++)
         step(W'(c), 1'b0, 2'b11);
      for (int c = 0; c < 40; c++)
         step(W'(c), 1'b1, 2'((c / 5) % 4));
      for (int c = 0; c < 140; c++)
         step(W'(15 - (c % 16)), c[0] | c[1], 2'b11);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule